// File: doc/BRIEF.md
# Convert-Start Sequencer with Automatic Power-Down

This block is the digital control core of a low-power 8-bit sampling converter. A single asynchronous convert-start line drives it. A rising edge wakes the converter from its low-current state and starts an internal power-up timer. A falling edge places the track/hold in hold and starts a conversion whose length is set by a cycle counter. At the end of the conversion the block strobes the result word from a behavioural SAR model into an output register. It then reads the level of the convert-start line to choose between two paths. If the line is high, the converter stays powered for high-speed back-to-back sampling. If the line is low, the converter powers down.

The block has no mode register, and the only mode selection is that level sampled at the end of conversion. A start pulse can be shorter than the power-up interval. In that case the falling edge is remembered, and the conversion begins only once the internal power-up count has expired. A conversion therefore never starts on an unpowered converter. After the end of conversion the track/hold returns to tracking. It keeps tracking until the next falling edge.

Top module: `cnv_seq`

## Requirements
- R1: After reset is released, and while the convert-start line stays low, pwr_en_o, hold_o, busy_o and latch_o are 0 and result_o is 0.
- R2: The convert-start line passes through a two-flop synchroniser. A rising edge while powered down raises pwr_en_o at the third rising clock edge after the input change. The power-up interval then runs for PWRUP_CYC clock cycles.
- R3: If the convert-start line falls after power-up has completed, hold_o rises at the third rising clock edge after the fall. It stays high for exactly CONV_CYC cycles.
- R4: A fall that arrives during the power-up interval is remembered. hold_o then rises exactly PWRUP_CYC cycles after pwr_en_o rose. hold_o never rises while pwr_en_o is low.
- R5: busy_o rises at the third rising clock edge after the accepted fall, including a fall that is held off during power-up. busy_o falls in the same cycle as the latch strobe.
- R6: In the cycle after the last hold cycle, latch_o is high for exactly one cycle, result_o takes the value on sar_result_i, and hold_o is low. result_o does not change at any other time.
- R7: If the synchronised convert-start level is high at the end of conversion, pwr_en_o stays high. A later fall then starts a conversion three cycles after it, with no power-up interval.
- R8: If that level is low at the end of conversion, pwr_en_o falls in the same cycle as the latch strobe.
- R9: Rising and falling edges of convert-start during a conversion are ignored. The hold length and the strobe cycle stay unchanged.
- R10: A rising edge of convert-start while the converter is already powered, whether powering up, tracking or converting, does not restart power-up or delay a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnv_i | input | 1 | Asynchronous convert-start line |
| sar_result_i | input | RES_W | Conversion word from the SAR model |
| pwr_en_o | output | 1 | Converter analog power enable |
| hold_o | output | 1 | Track/hold in hold (conversion running) |
| busy_o | output | 1 | Conversion accepted and not yet latched |
| latch_o | output | 1 | One-cycle result latch strobe |
| result_o | output | RES_W | Latched conversion result |

## Verification
The main sweep steps the falling edge through every cycle offset from one cycle after the wake-up edge to three cycles past the end of power-up. Each offset is run once with the line left low and once with it raised again. This separates a deferred start from an immediate one, and the stay-awake path from the power-down path, at the exact boundary cycle. Further runs toggle the line inside a conversion to show that those edges are ignored. Another run issues a second fall from the powered idle state to show that the power-up interval is skipped. Every output is compared cycle by cycle against arithmetic predictions from the sweep offset.

// File: rtl/cnv_seq_pkg.sv
package cnv_seq_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_WAKE  = 2'd1,
    ST_READY = 2'd2,
    ST_CONV  = 2'd3
  } seq_st_e;
endpackage

// File: rtl/cnv_seq_sync.sv
module cnv_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], a_i};
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];

  // R2
  edge_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/cnv_seq_timer.sv
module cnv_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);

  // R3
  cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));
endmodule

// File: rtl/cnv_seq.sv
module cnv_seq
  import cnv_seq_pkg::*;
#(
  parameter int PWRUP_CYC = 150,
  parameter int CONV_CYC  = 500,
  parameter int RES_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnv_i,
  input  logic [RES_W-1:0] sar_result_i,
  output logic             pwr_en_o,
  output logic             hold_o,
  output logic             busy_o,
  output logic             latch_o,
  output logic [RES_W-1:0] result_o
);
  localparam int MAX_CYC = (PWRUP_CYC > CONV_CYC) ? PWRUP_CYC : CONV_CYC;
  localparam int TW      = $clog2(MAX_CYC + 1);
  localparam logic [TW-1:0] PW_V = TW'(PWRUP_CYC - 1);
  localparam logic [TW-1:0] CV_V = TW'(CONV_CYC - 1);

  logic lvl, rise, fall, zero;
  logic ld;
  logic [TW-1:0] ld_val;
  seq_st_e st_q, st_d;
  logic pend_q, pend_d, latch_q, latch_d;
  logic [RES_W-1:0] res_q, res_d;

  cnv_seq_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .a_i(cnv_i),
    .lvl_o (lvl), .rise_o(rise), .fall_o(fall)
  );

  cnv_seq_timer #(.W(TW)) u_tmr (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(ld), .val_i(ld_val), .zero_o(zero)
  );

  always_comb begin
    st_d    = st_q;
    pend_d  = pend_q;
    latch_d = 1'b0;
    res_d   = res_q;
    ld      = 1'b0;
    ld_val  = PW_V;
    unique case (st_q)
      ST_OFF: if (rise) begin
        st_d = ST_WAKE;
        ld   = 1'b1;
      end
      ST_WAKE: begin
        if (fall) pend_d = 1'b1;
        if (zero) begin
          if (pend_q || fall) begin
            st_d   = ST_CONV;
            ld     = 1'b1;
            ld_val = CV_V;
            pend_d = 1'b0;
          end else begin
            st_d = ST_READY;
          end
        end
      end
      ST_READY: if (fall) begin
        st_d   = ST_CONV;
        ld     = 1'b1;
        ld_val = CV_V;
      end
      ST_CONV: if (zero) begin
        latch_d = 1'b1;
        res_d   = sar_result_i;
        st_d    = lvl ? ST_READY : ST_OFF;
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_OFF;
      pend_q  <= 1'b0;
      latch_q <= 1'b0;
      res_q   <= '0;
    end else begin
      st_q    <= st_d;
      pend_q  <= pend_d;
      latch_q <= latch_d;
      res_q   <= res_d;
    end
  end

  assign pwr_en_o = (st_q != ST_OFF);
  assign hold_o   = (st_q == ST_CONV);
  assign busy_o   = pend_q || (st_q == ST_CONV);
  assign latch_o  = latch_q;
  assign result_o = res_q;

  // R4
  no_unpowered_conv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> $past(pwr_en_o));
  // R6
  strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |=> !latch_o);
  // R6
  hold_end_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> latch_o);
  // R5
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> latch_o);
  // R8
  down_at_eoc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_en_o) |-> latch_o);
  // R6
  result_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_o |-> $stable(result_o));
endmodule

// File: tb/sim_cnv_seq.sv
module sim_cnv_seq;
  localparam int PW = 4;
  localparam int CV = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0;
  logic [7:0] sar = '0;
  logic pwr_en, hold, busy, latch;
  logic [7:0] result;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cnv_seq #(.PWRUP_CYC(PW), .CONV_CYC(CV), .RES_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cnv_i(cs), .sar_result_i(sar),
    .pwr_en_o(pwr_en), .hold_o(hold), .busy_o(busy), .latch_o(latch),
    .result_o(result)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cs    = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pwr_en == 0, "R1", "pwr_en", pwr_en, 0);
    chk(hold == 0,   "R1", "hold", hold, 0);
    chk(busy == 0,   "R1", "busy", busy, 0);
    chk(latch == 0,  "R1", "latch", latch, 0);
    chk(result == 0, "R1", "result", result, 0);
  endtask

  task automatic trial(input int d, input bit stay, input bit glitch);
    int cs_i;
    int en;
    logic [7:0] val;
    string hreq;
    string preq;
    cs_i = ((d > PW) ? d : PW) + 3;
    en   = cs_i + CV;
    val  = 8'(d * 29 + int'(stay) * 7 + int'(glitch) * 3 + 11);
    sar  = val;
    do_reset();
    for (int i = 0; i <= en + 3; i++) begin
      if (i > 0) @(negedge clk);
      hreq = glitch ? "R9" : (stay ? "R10" : ((d < PW) ? "R4" : "R3"));
      preq = (i < en) ? "R2" : (stay ? "R7" : "R8");
      chk(pwr_en == ((i >= 3) && (i < en || stay)), preq, "pwr_en", pwr_en,
          int'((i >= 3) && (i < en || stay)));
      chk(hold == ((i >= cs_i) && (i < en)), hreq, "hold", hold,
          int'((i >= cs_i) && (i < en)));
      chk(busy == ((i >= d + 3) && (i < en)), "R5", "busy", busy,
          int'((i >= d + 3) && (i < en)));
      chk(latch == (i == en), "R6", "latch", latch, int'(i == en));
      chk(result == ((i >= en) ? val : 8'd0), "R6", "result", result,
          (i >= en) ? int'(val) : 0);
      if (i == 0)                    cs = 1'b1;
      else if (i == d)               cs = 1'b0;
      else if (stay && i == d + 1)   cs = 1'b1;
      if (glitch && i == cs_i + 1)   cs = 1'b1;
      if (glitch && i == cs_i + 2)   cs = 1'b0;
    end
    if (stay) begin
      // R7 back-to-back conversion from powered idle, no power-up interval
      val = val ^ 8'hA5;
      sar = val;
      for (int j = 0; j <= 3 + CV + 2; j++) begin
        if (j > 0) @(negedge clk);
        chk(pwr_en == (j < 3 + CV), "R7", "pwr_en again", pwr_en, int'(j < 3 + CV));
        chk(hold == ((j >= 3) && (j < 3 + CV)), "R7", "hold again", hold,
            int'((j >= 3) && (j < 3 + CV)));
        chk(latch == (j == 3 + CV), "R7", "latch again", latch, int'(j == 3 + CV));
        if (j >= 3 + CV)
          chk(result == val, "R7", "result again", result, val);
        if (j == 0) cs = 1'b0;
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int s = 0; s < 2; s++)
      for (int d = 1; d <= PW + 3; d++)
        trial(d, s[0], 1'b0);
    trial(1, 1'b0, 1'b1);
    trial(PW + 2, 1'b0, 1'b1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule